// File: doc/BRIEF.md
# Lockable Fully Associative Translation Buffer

This block caches virtual-to-physical page translations for one memory management unit. It has 32 entries, and any virtual page may sit in any of them. Each entry holds a virtual page number, a physical page number, a 4-bit domain number, a 2-bit page permission code and a small cache-attribute field. A request is looked up against every valid entry at once. A hit returns the translated address one cycle after acceptance, and the domain and permission rules decide whether the access is aborted.

A miss raises a walk request towards an external page-table walker and then waits for the returned descriptor. The descriptor is written into a victim entry chosen in round-robin order, and the request is replayed against the buffer so that it completes through the entry just written. A lock count protects the lowest entries from replacement and from invalidation. A global enable sends addresses straight through when translation is off. A single-cycle pulse invalidates every unlocked entry.

Top module: `tlb_xlate`

## Requirements
- R1: The buffer holds 32 entries, and any page may occupy any entry. Once 32 distinct pages have been filled, all 32 hit with no walk.
- R2: Fills take victims in round-robin order over the unlocked range. After a full cycle of fills, the next fill replaces the entry filled earliest in that cycle, and the entry after it stays resident.
- R3: A pulse on `lock_we_i` loads the lock count from `lock_cnt_i` (0 to 31), and entries with an index below it are never replaced. The victim pointer stays between the lock count and 31. It moves up to the lock count when the count is raised past it, and it wraps back to the lock count after entry 31. Entry 31 therefore always remains replaceable.
- R4: On a miss with translation enabled, `walk_valid_o` rises and is held with a stable `walk_vpn_o` (address bits 31:12) until `walk_ready_i`. Then `fill_ready_o` rises. A descriptor taken with `fill_valid_i` is written into the victim entry, and the request is replayed, giving a response three cycles after the walk request appears.
- R5: A hit is answered on the cycle after acceptance with no walk. `rsp_pa_o` equals the physical page number concatenated with address bits 11:0, and `rsp_attr_o` equals the entry's attribute field.
- R6: Domain n takes its 2-bit code from `dom_ctl_i[2n+1:2n]`. Code 00 and code 10 always abort. Code 11 never aborts. Code 01 applies the page permission check.
- R7: The page permission codes are: 00 allows reads and writes at any privilege, 01 allows reads only, so any write aborts, and 10 or 11 allows only privileged accesses (`req_priv_i`=1). An abort is reported with `rsp_abort_o`=1 on the response.
- R8: When `en_i` is low at acceptance, the response comes one cycle later with `rsp_pa_o` equal to the request address, attributes 0 and no abort, and no walk is started.
- R9: After reset, `req_ready_o` is 1 and `rsp_valid_o` and `walk_valid_o` are 0. Only one miss is outstanding: `req_ready_o` stays low from the acceptance of a miss until its response.
- R10: A one-cycle `inval_i` clears every entry at or above the lock count, so those pages miss afterwards. Locked entries keep hitting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Translation and checking enable |
| inval_i | input | 1 | Invalidate all unlocked entries |
| lock_we_i | input | 1 | Load the lock count |
| lock_cnt_i | input | 5 | New lock count |
| dom_ctl_i | input | 32 | Sixteen 2-bit domain access codes |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high |
| req_va_i | input | 32 | Virtual address |
| req_write_i | input | 1 | Access is a write |
| req_priv_i | input | 1 | Access is privileged |
| rsp_valid_o | output | 1 | One-cycle response strobe |
| rsp_pa_o | output | 32 | Physical address |
| rsp_attr_o | output | 4 | Cache attributes of the page |
| rsp_abort_o | output | 1 | Access aborted |
| walk_valid_o | output | 1 | Walk request |
| walk_ready_i | input | 1 | Walker took the request |
| walk_vpn_o | output | 20 | Virtual page to walk |
| fill_valid_i | input | 1 | Descriptor valid |
| fill_ready_o | output | 1 | Descriptor can be taken |
| fill_ppn_i | input | 20 | Physical page number |
| fill_dom_i | input | 4 | Domain number |
| fill_ap_i | input | 2 | Page permission code |
| fill_attr_i | input | 4 | Cache attributes |

## Verification
A table of accesses combines reads and writes, user and privileged accesses, the four domain codes and three page permission codes, across both the miss and the hit path. This separates a domain decision from a page decision and a filled translation from a resident one. Directed sequences then run the same abort-prone page with translation disabled, set the lock count to 31 so that two pages compete for entry 31, and invalidate with and without locks. A final sequence fills 32 fresh pages and then one more, and checks which page was evicted. These cases tell round-robin replacement apart from lowest-free or most-recent replacement, and locked entries apart from unlocked ones.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WALK   = 2'd1,
        ST_FILL   = 2'd2,
        ST_REPLAY = 2'd3
    } tlb_state_e;

    // domain access codes
    localparam logic [1:0] DOM_NONE   = 2'b00;
    localparam logic [1:0] DOM_CLIENT = 2'b01;
    localparam logic [1:0] DOM_RSVD   = 2'b10;
    localparam logic [1:0] DOM_MGR    = 2'b11;

    // page permission codes
    localparam logic [1:0] AP_FULL    = 2'b00;
    localparam logic [1:0] AP_RDONLY  = 2'b01;

endpackage

// File: rtl/tlb_perm.sv
module tlb_perm #(
    parameter int DOM_N = 16,
    parameter int DOM_W = 4
) (
    input  logic [2*DOM_N-1:0] dom_ctl_i,
    input  logic [DOM_W-1:0]   dom_i,
    input  logic [1:0]         ap_i,
    input  logic               write_i,
    input  logic               priv_i,
    output logic               abort_o
);
    import tlb_pkg::*;

    logic [1:0] code;
    logic       page_deny;

    always_comb begin
        code = dom_ctl_i[2*dom_i +: 2];
        case (ap_i)
            AP_FULL:   page_deny = 1'b0;
            AP_RDONLY: page_deny = write_i;
            default:   page_deny = !priv_i;
        endcase
        case (code)
            DOM_CLIENT: abort_o = page_deny;
            DOM_MGR:    abort_o = 1'b0;
            default:    abort_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int N  = 32,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lock_we_i,
    input  logic [IW-1:0] lock_val_i,
    input  logic          adv_i,
    output logic [IW-1:0] lock_o,
    output logic [IW-1:0] victim_o
);

    typedef struct packed {
        logic [IW-1:0] lock;
        logic [IW-1:0] ptr;
    } vic_t;

    vic_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (adv_i) begin
            s_d.ptr = (s_q.ptr == IW'(N-1)) ? s_q.lock : s_q.ptr + 1'b1;
        end
        if (lock_we_i) begin
            s_d.lock = lock_val_i;
        end
        if (s_d.ptr < s_d.lock) begin
            s_d.ptr = s_d.lock;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign lock_o   = s_q.lock;
    assign victim_o = s_q.ptr;

    AST_PTR_ABOVE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.ptr >= s_q.lock); // R3

    AST_WRAP_TO_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !lock_we_i && s_q.ptr == IW'(N-1)) |=> (s_q.ptr == $past(s_q.lock))); // R2

endmodule

// File: rtl/tlb_cam.sv
module tlb_cam #(
    parameter int N      = 32,
    parameter int IW     = $clog2(N),
    parameter int VPN_W  = 20,
    parameter int DOM_W  = 4,
    parameter int ATTR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VPN_W-1:0]  lk_vpn_i,
    input  logic              inval_i,
    input  logic [IW-1:0]     lock_i,
    input  logic              wr_i,
    input  logic [IW-1:0]     wr_idx_i,
    input  logic [VPN_W-1:0]  wr_vpn_i,
    input  logic [VPN_W-1:0]  wr_ppn_i,
    input  logic [DOM_W-1:0]  wr_dom_i,
    input  logic [1:0]        wr_ap_i,
    input  logic [ATTR_W-1:0] wr_attr_i,
    output logic              hit_o,
    output logic [VPN_W-1:0]  hit_ppn_o,
    output logic [DOM_W-1:0]  hit_dom_o,
    output logic [1:0]        hit_ap_o,
    output logic [ATTR_W-1:0] hit_attr_o
);

    typedef struct packed {
        logic              v;
        logic [VPN_W-1:0]  vpn;
        logic [VPN_W-1:0]  ppn;
        logic [DOM_W-1:0]  dom;
        logic [1:0]        ap;
        logic [ATTR_W-1:0] attr;
    } ent_t;

    ent_t       ent_d [N];
    ent_t       ent_q [N];
    ent_t       sel;
    logic [N-1:0] match;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = ent_q[g].v && (ent_q[g].vpn == lk_vpn_i);
    end

    always_comb begin
        sel = '0;
        for (int i = N-1; i >= 0; i--) begin
            if (match[i]) sel = ent_q[i];
        end
    end

    assign hit_o      = |match;
    assign hit_ppn_o  = sel.ppn;
    assign hit_dom_o  = sel.dom;
    assign hit_ap_o   = sel.ap;
    assign hit_attr_o = sel.attr;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            ent_d[i] = ent_q[i];
            if (inval_i && (IW'(i) >= lock_i)) ent_d[i].v = 1'b0;
            if (wr_i && (wr_idx_i == IW'(i))) begin
                ent_d[i] = '{v: 1'b1, vpn: wr_vpn_i, ppn: wr_ppn_i,
                             dom: wr_dom_i, ap: wr_ap_i, attr: wr_attr_i};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) ent_q[i] <= '0;
        end else begin
            for (int i = 0; i < N; i++) ent_q[i] <= ent_d[i];
        end
    end

    AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match)); // R1

endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate #(
    parameter  int ENTRIES = 32,
    parameter  int VA_W    = 32,
    parameter  int PG_W    = 12,
    parameter  int DOM_N   = 16,
    parameter  int ATTR_W  = 4,
    localparam int IW      = $clog2(ENTRIES),
    localparam int VPN_W   = VA_W - PG_W,
    localparam int DOM_W   = $clog2(DOM_N)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_i,
    input  logic               inval_i,
    input  logic               lock_we_i,
    input  logic [IW-1:0]      lock_cnt_i,
    input  logic [2*DOM_N-1:0] dom_ctl_i,
    input  logic               req_valid_i,
    output logic               req_ready_o,
    input  logic [VA_W-1:0]    req_va_i,
    input  logic               req_write_i,
    input  logic               req_priv_i,
    output logic               rsp_valid_o,
    output logic [VA_W-1:0]    rsp_pa_o,
    output logic [ATTR_W-1:0]  rsp_attr_o,
    output logic               rsp_abort_o,
    output logic               walk_valid_o,
    input  logic               walk_ready_i,
    output logic [VPN_W-1:0]   walk_vpn_o,
    input  logic               fill_valid_i,
    output logic               fill_ready_o,
    input  logic [VPN_W-1:0]   fill_ppn_i,
    input  logic [DOM_W-1:0]   fill_dom_i,
    input  logic [1:0]         fill_ap_i,
    input  logic [ATTR_W-1:0]  fill_attr_i
);
    import tlb_pkg::*;

    typedef struct packed {
        tlb_state_e        st;
        logic [VA_W-1:0]   va;
        logic              wr;
        logic              pv;
        logic              rv;
        logic [VA_W-1:0]   pa;
        logic [ATTR_W-1:0] attr;
        logic              ab;
    } ctl_t;

    ctl_t s_d, s_q;

    logic              replay;
    logic [VPN_W-1:0]  lk_vpn;
    logic              chk_wr, chk_pv;
    logic              hit;
    logic [VPN_W-1:0]  hit_ppn;
    logic [DOM_W-1:0]  hit_dom;
    logic [1:0]        hit_ap;
    logic [ATTR_W-1:0] hit_attr;
    logic              perm_ab;
    logic              fill_we;
    logic [IW-1:0]     lock_cnt;
    logic [IW-1:0]     victim;

    assign replay = (s_q.st == ST_REPLAY);
    assign lk_vpn = replay ? s_q.va[VA_W-1:PG_W] : req_va_i[VA_W-1:PG_W];
    assign chk_wr = replay ? s_q.wr : req_write_i;
    assign chk_pv = replay ? s_q.pv : req_priv_i;

    tlb_cam #(
        .N(ENTRIES), .IW(IW), .VPN_W(VPN_W), .DOM_W(DOM_W), .ATTR_W(ATTR_W)
    ) u_cam (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_vpn_i   (lk_vpn),
        .inval_i    (inval_i),
        .lock_i     (lock_cnt),
        .wr_i       (fill_we),
        .wr_idx_i   (victim),
        .wr_vpn_i   (s_q.va[VA_W-1:PG_W]),
        .wr_ppn_i   (fill_ppn_i),
        .wr_dom_i   (fill_dom_i),
        .wr_ap_i    (fill_ap_i),
        .wr_attr_i  (fill_attr_i),
        .hit_o      (hit),
        .hit_ppn_o  (hit_ppn),
        .hit_dom_o  (hit_dom),
        .hit_ap_o   (hit_ap),
        .hit_attr_o (hit_attr)
    );

    tlb_victim #(.N(ENTRIES), .IW(IW)) u_vic (
        .clk        (clk),
        .rst_n      (rst_n),
        .lock_we_i  (lock_we_i),
        .lock_val_i (lock_cnt_i),
        .adv_i      (fill_we),
        .lock_o     (lock_cnt),
        .victim_o   (victim)
    );

    tlb_perm #(.DOM_N(DOM_N), .DOM_W(DOM_W)) u_perm (
        .dom_ctl_i (dom_ctl_i),
        .dom_i     (hit_dom),
        .ap_i      (hit_ap),
        .write_i   (chk_wr),
        .priv_i    (chk_pv),
        .abort_o   (perm_ab)
    );

    always_comb begin
        s_d     = s_q;
        s_d.rv  = 1'b0;
        fill_we = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (req_valid_i) begin
                    s_d.va = req_va_i;
                    s_d.wr = req_write_i;
                    s_d.pv = req_priv_i;
                    if (!en_i) begin
                        s_d.rv   = 1'b1;
                        s_d.pa   = req_va_i;
                        s_d.attr = '0;
                        s_d.ab   = 1'b0;
                    end else if (hit) begin
                        s_d.rv   = 1'b1;
                        s_d.pa   = {hit_ppn, req_va_i[PG_W-1:0]};
                        s_d.attr = hit_attr;
                        s_d.ab   = perm_ab;
                    end else begin
                        s_d.st = ST_WALK;
                    end
                end
            end
            ST_WALK: begin
                if (walk_ready_i) s_d.st = ST_FILL;
            end
            ST_FILL: begin
                if (fill_valid_i) begin
                    fill_we = 1'b1;
                    s_d.st  = ST_REPLAY;
                end
            end
            ST_REPLAY: begin
                if (hit) begin
                    s_d.rv   = 1'b1;
                    s_d.pa   = {hit_ppn, s_q.va[PG_W-1:0]};
                    s_d.attr = hit_attr;
                    s_d.ab   = perm_ab;
                    s_d.st   = ST_IDLE;
                end else begin
                    s_d.st = ST_WALK;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign req_ready_o  = (s_q.st == ST_IDLE);
    assign walk_valid_o = (s_q.st == ST_WALK);
    assign walk_vpn_o   = s_q.va[VA_W-1:PG_W];
    assign fill_ready_o = (s_q.st == ST_FILL);
    assign rsp_valid_o  = s_q.rv;
    assign rsp_pa_o     = s_q.pa;
    assign rsp_attr_o   = s_q.attr;
    assign rsp_abort_o  = s_q.ab;

    AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_ready_o && !en_i) |=>
        (rsp_valid_o && rsp_pa_o == $past(req_va_i) && !rsp_abort_o && !walk_valid_o)); // R8

    AST_HIT_NO_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_ready_o && en_i && hit) |=> (rsp_valid_o && !walk_valid_o)); // R5

    AST_WALK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_valid_o && !walk_ready_i) |=> (walk_valid_o && $stable(walk_vpn_o))); // R4

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_ready_o && en_i && !hit) |=> (!req_ready_o && !rsp_valid_o)); // R9

    AST_FILL_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid_i && fill_ready_o) |-> (victim >= lock_cnt)); // R3

endmodule

// File: tb/sim_tlb_xlate.sv
module sim_tlb_xlate;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_i = 1'b1;
    logic        inval_i = 1'b0;
    logic        lock_we_i = 1'b0;
    logic [4:0]  lock_cnt_i = '0;
    logic [31:0] dom_ctl_i = 32'h5555_558D;
    logic        req_valid_i = 1'b0;
    logic        req_ready_o;
    logic [31:0] req_va_i = '0;
    logic        req_write_i = 1'b0;
    logic        req_priv_i = 1'b0;
    logic        rsp_valid_o;
    logic [31:0] rsp_pa_o;
    logic [3:0]  rsp_attr_o;
    logic        rsp_abort_o;
    logic        walk_valid_o;
    logic        walk_ready_i = 1'b0;
    logic [19:0] walk_vpn_o;
    logic        fill_valid_i = 1'b0;
    logic        fill_ready_o;
    logic [19:0] fill_ppn_i = '0;
    logic [3:0]  fill_dom_i = '0;
    logic [1:0]  fill_ap_i = '0;
    logic [3:0]  fill_attr_i = '0;

    int nchk = 0;
    int nfail = 0;

    always #2 clk = ~clk;

    tlb_xlate u0 (.*);

    typedef struct packed {
        logic [31:0] va;
        logic        wr;
        logic        pv;
        logic [19:0] ppn;
        logic [3:0]  dom;
        logic [1:0]  ap;
        logic [3:0]  attr;
        logic        walk;
        logic        ab;
    } vec_t;

    // domains: 0 client, 1 manager, 2 none, 3 reserved(none)
    localparam vec_t VEC [0:9] = '{
        '{32'h0001_0123, 1'b0, 1'b0, 20'h80001, 4'd0, 2'b00, 4'h3, 1'b1, 1'b0},
        '{32'h0001_0FFC, 1'b1, 1'b0, 20'h80001, 4'd0, 2'b00, 4'h3, 1'b0, 1'b0},
        '{32'h0002_0000, 1'b1, 1'b0, 20'h80002, 4'd0, 2'b01, 4'h5, 1'b1, 1'b1},
        '{32'h0002_0004, 1'b0, 1'b0, 20'h80002, 4'd0, 2'b01, 4'h5, 1'b0, 1'b0},
        '{32'h0003_0010, 1'b0, 1'b0, 20'h80003, 4'd0, 2'b10, 4'h6, 1'b1, 1'b1},
        '{32'h0003_0010, 1'b1, 1'b1, 20'h80003, 4'd0, 2'b10, 4'h6, 1'b0, 1'b0},
        '{32'h0004_0000, 1'b1, 1'b0, 20'h80004, 4'd1, 2'b01, 4'h7, 1'b1, 1'b0},
        '{32'h0005_0000, 1'b0, 1'b1, 20'h80005, 4'd2, 2'b00, 4'h8, 1'b1, 1'b1},
        '{32'h0006_0000, 1'b0, 1'b1, 20'h80006, 4'd3, 2'b00, 4'h9, 1'b1, 1'b1},
        '{32'h0002_0008, 1'b1, 1'b1, 20'h80002, 4'd0, 2'b01, 4'h5, 1'b0, 1'b1}
    };

    task automatic chk(input logic ok, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic access(input logic [31:0] va, input logic wr, input logic pv,
                          input logic [19:0] ppn, input logic [3:0] dom,
                          input logic [1:0] ap, input logic [3:0] attr,
                          output logic walked, output int lat,
                          output logic [31:0] pa, output logic [3:0] at,
                          output logic ab);
        logic busy_ok;
        walked  = 1'b0;
        lat     = 0;
        busy_ok = 1'b1;
        @(negedge clk);
        req_va_i = va; req_write_i = wr; req_priv_i = pv; req_valid_i = 1'b1;
        @(negedge clk);
        req_valid_i = 1'b0;
        while (!rsp_valid_o && lat < 50) begin
            if (req_ready_o) busy_ok = 1'b0;
            if (walk_valid_o && !walk_ready_i) begin
                walked = 1'b1;
                chk(walk_vpn_o == va[31:12], "R4 walk page number", 64'(walk_vpn_o), 64'(va[31:12]));
                walk_ready_i = 1'b1;
            end else begin
                walk_ready_i = 1'b0;
            end
            if (fill_ready_o) begin
                fill_valid_i = 1'b1;
                fill_ppn_i = ppn; fill_dom_i = dom; fill_ap_i = ap; fill_attr_i = attr;
            end else begin
                fill_valid_i = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        walk_ready_i = 1'b0;
        fill_valid_i = 1'b0;
        pa = rsp_pa_o; at = rsp_attr_o; ab = rsp_abort_o;
        if (walked) begin
            chk(busy_ok, "R9 ready low while miss outstanding", 64'(busy_ok), 64'd1);
            chk(lat == 3, "R4 replay latency", 64'(lat), 64'd3);
        end
    endtask

    task automatic pulse_lock(input logic [4:0] val);
        @(negedge clk);
        lock_cnt_i = val; lock_we_i = 1'b1;
        @(negedge clk);
        lock_we_i = 1'b0;
    endtask

    task automatic pulse_inval();
        @(negedge clk);
        inval_i = 1'b1;
        @(negedge clk);
        inval_i = 1'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic        w, ab;
        int          lat;
        logic [31:0] pa;
        logic [3:0]  at;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready_o == 1'b1, "R9 reset ready", 64'(req_ready_o), 64'd1);
        chk(rsp_valid_o == 1'b0, "R9 reset response idle", 64'(rsp_valid_o), 64'd0);
        chk(walk_valid_o == 1'b0, "R9 reset walk idle", 64'(walk_valid_o), 64'd0);

        // vector table: R4 R5 R6 R7
        for (int k = 0; k < 10; k++) begin
            access(VEC[k].va, VEC[k].wr, VEC[k].pv, VEC[k].ppn, VEC[k].dom,
                   VEC[k].ap, VEC[k].attr, w, lat, pa, at, ab);
            chk(w == VEC[k].walk, "R4/R5 walk on miss only", 64'(w), 64'(VEC[k].walk));
            chk(ab == VEC[k].ab, "R6/R7 abort decision", 64'(ab), 64'(VEC[k].ab));
            if (!VEC[k].ab) begin
                chk(pa == {VEC[k].ppn, VEC[k].va[11:0]}, "R5 translated address",
                    64'(pa), 64'({VEC[k].ppn, VEC[k].va[11:0]}));
                chk(at == VEC[k].attr, "R5 attributes", 64'(at), 64'(VEC[k].attr));
            end
            if (!VEC[k].walk) chk(lat == 0, "R5 hit latency", 64'(lat), 64'd0);
        end

        // R8: bypass on a page whose domain would abort
        en_i = 1'b0;
        access(32'h0005_0ABC, 1'b1, 1'b0, 20'h0, 4'd0, 2'b00, 4'h0, w, lat, pa, at, ab);
        chk(!w, "R8 no walk when disabled", 64'(w), 64'd0);
        chk(pa == 32'h0005_0ABC, "R8 pass-through address", 64'(pa), 64'h0005_0ABC);
        chk(!ab, "R8 no abort when disabled", 64'(ab), 64'd0);
        chk(at == 4'h0, "R8 attributes zero", 64'(at), 64'd0);
        en_i = 1'b1;

        // R3: lock 0..30, only entry 31 replaceable
        pulse_lock(5'd31);
        access(32'h0100_0000, 1'b0, 1'b1, 20'h11111, 4'd1, 2'b00, 4'h1, w, lat, pa, at, ab);
        chk(w, "R3 page X filled", 64'(w), 64'd1);
        access(32'h0101_0000, 1'b0, 1'b1, 20'h22222, 4'd1, 2'b00, 4'h2, w, lat, pa, at, ab);
        chk(w, "R3 page Y filled", 64'(w), 64'd1);
        access(32'h0100_0000, 1'b0, 1'b1, 20'h11111, 4'd1, 2'b00, 4'h1, w, lat, pa, at, ab);
        chk(w, "R3 page X evicted via entry 31", 64'(w), 64'd1);
        access(32'h0001_0000, 1'b0, 1'b0, 20'h80001, 4'd0, 2'b00, 4'h3, w, lat, pa, at, ab);
        chk(!w, "R3 locked entry kept", 64'(w), 64'd0);
        chk(pa == 32'h8000_1000, "R3 locked translation", 64'(pa), 64'h8000_1000);

        // R10: invalidate with locks in place
        pulse_inval();
        access(32'h0001_0000, 1'b0, 1'b0, 20'h80001, 4'd0, 2'b00, 4'h3, w, lat, pa, at, ab);
        chk(!w, "R10 locked entry survives invalidate", 64'(w), 64'd0);
        access(32'h0100_0000, 1'b0, 1'b1, 20'h11111, 4'd1, 2'b00, 4'h1, w, lat, pa, at, ab);
        chk(w, "R10 unlocked entry cleared", 64'(w), 64'd1);

        // R10: full invalidate with no locks
        pulse_lock(5'd0);
        pulse_inval();
        access(32'h0001_0000, 1'b0, 1'b0, 20'h80001, 4'd0, 2'b00, 4'h3, w, lat, pa, at, ab);
        chk(w, "R10 former locked page now misses", 64'(w), 64'd1);

        // R1 R2: 32 fresh pages, then one more
        for (int k = 0; k < 32; k++) begin
            access(32'h0200_0000 + (k << 12), 1'b0, 1'b0, 20'h90000 + 20'(k), 4'd0, 2'b00,
                   4'hA, w, lat, pa, at, ab);
            chk(w, "R1 fresh page walks", 64'(w), 64'd1);
        end
        for (int k = 0; k < 32; k++) begin
            access(32'h0200_0000 + (k << 12), 1'b0, 1'b0, 20'h0, 4'd0, 2'b00,
                   4'h0, w, lat, pa, at, ab);
            chk(!w && pa == {20'h90000 + 20'(k), 12'h000}, "R1 all 32 resident",
                64'(pa), 64'({20'h90000 + 20'(k), 12'h000}));
        end
        access(32'h0300_0000, 1'b0, 1'b0, 20'hABCDE, 4'd0, 2'b00, 4'hB, w, lat, pa, at, ab);
        chk(w, "R2 extra page walks", 64'(w), 64'd1);
        access(32'h0200_1000, 1'b0, 1'b0, 20'h0, 4'd0, 2'b00, 4'h0, w, lat, pa, at, ab);
        chk(!w, "R2 second-oldest page kept", 64'(w), 64'd0);
        access(32'h0200_0000, 1'b0, 1'b0, 20'h90000, 4'd0, 2'b00, 4'hA, w, lat, pa, at, ab);
        chk(w, "R2 oldest page replaced", 64'(w), 64'd1);

        summary();
        $finish;
    end

endmodule